// File: doc/BRIEF.md
# Streaming 3x3 Median Filter

This block removes impulse noise from a raster stream of 8-bit grayscale pixels. Pixels arrive with three strobes: a frame-sync level that marks the gap between frames, a line-valid level that frames each line, and a pixel-enable that marks the cycles carrying a pixel. Two line memories keep the two rows already received. Three shift registers, one for each row, give the three columns of a 3x3 neighbourhood. The median of that neighbourhood replaces the pixel, and the three strobes come out delayed so they stay lined up with the filtered data.

The median does not come from a nine-value sort. A registered three-stage network of three-input sorts finds it. The first stage orders each window row. The second stage orders the row maxima, the row middles and the row minima as three groups. From those groups it keeps the smallest maximum, the middle of the middles and the largest minimum. The third stage outputs the middle of those three values.

The window has its bottom-right sample at the pixel now being accepted. The filtered image therefore comes out shifted by one row and one column relative to the input. Positions where a full window cannot yet exist pass the incoming pixel through unchanged. The frame width is a parameter.

Top module: `median3x3_stream`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all outputs are zero.
- R2: A pixel is accepted when `in_de` and `in_href` are both high. For an accepted pixel at line r and column c of a frame, with r >= 2 and c >= 2, the output pixel is the median (the 5th smallest) of the nine accepted pixels in lines r-2..r and columns c-2..c.
- R3: For an accepted pixel with r < 2 or c < 2, the output pixel equals that input pixel unchanged.
- R4: `out_vsync`, `out_href` and `out_de` equal `in_vsync`, `in_href` and `in_de` delayed by exactly 4 clock cycles. The output pixel for an accepted input shows in the cycle where its delayed enable is high.
- R5: `out_pix` is 0 in every cycle in which `out_href` is low.
- R6: The column index restarts at 0 whenever `in_href` is low. Cycles with `in_de` low inside a line, and cycles with `in_de` high while `in_href` is low, change no later result.
- R7: The line index restarts at 0 whenever `in_vsync` is high. Each falling edge of `in_href` advances it, so the first two lines of every frame are pass-through again.
- R8: Pixels are unsigned 8-bit. Windows made only of 0s and 255s, including ties and single isolated extremes, give the exact median.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vsync | input | 1 | Frame-sync level, high between frames |
| in_href | input | 1 | Line-valid level |
| in_de | input | 1 | Pixel enable |
| in_pix | input | 8 | Input grayscale pixel |
| out_vsync | output | 1 | Frame-sync delayed by 4 cycles |
| out_href | output | 1 | Line-valid delayed by 4 cycles |
| out_de | output | 1 | Pixel enable delayed by 4 cycles |
| out_pix | output | 8 | Filtered or passed-through pixel, 0 outside lines |

## Verification
The hardest situation to reach from the ports is a window whose columns were collected across irregular timing. In that case the enable drops for several cycles inside a line, or strobes high during line blanking, between two samples that end up side by side in one window. The stimulus inserts random enable gaps between pixels and spurious enables during blanking. It also streams several frames back to back, so the line-index restart is exercised with stale data still in the line memories. Directed frames made of 0/255 checkerboards, flat 255 fields and a lone bright spike cover the tie and extreme cases.

// File: rtl/median3x3_stream.sv
module median3x3_stream #(
  parameter int WIDTH = 320,
  parameter int PW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vsync,
  input  logic          in_href,
  input  logic          in_de,
  input  logic [PW-1:0] in_pix,
  output logic          out_vsync,
  output logic          out_href,
  output logic          out_de,
  output logic [PW-1:0] out_pix
);

  localparam int CW  = (WIDTH > 2) ? $clog2(WIDTH) : 2;
  localparam int LAT = 4;
  localparam int TW  = 3 * PW;

  function automatic logic [TW-1:0] sort3(input logic [PW-1:0] a, b, c);
    logic [PW-1:0] x, y, hi, t, md, lo;
    x  = (a > b) ? a : b;
    y  = (a > b) ? b : a;
    hi = (x > c) ? x : c;
    t  = (x > c) ? c : x;
    md = (y > t) ? y : t;
    lo = (y > t) ? t : y;
    return {hi, md, lo};
  endfunction

  logic          acc;
  logic [CW-1:0] col;
  logic [1:0]    rowc;
  logic          href_q;

  logic [PW-1:0] lb_a [WIDTH];
  logic [PW-1:0] lb_b [WIDTH];
  logic [PW-1:0] w    [3][3];
  logic [PW-1:0] raw0, raw1, raw2;
  logic          bord0, bord1, bord2, bord_q;

  logic [TW-1:0] s1 [3];
  logic [PW-1:0] s2_hi, s2_md, s2_lo;
  logic [TW-1:0] s2_his, s2_mds, s2_los, s3_res;
  logic [PW-1:0] pix_q;

  logic [LAT-1:0] vs_sr, hr_sr, de_sr;

  assign acc = in_de && in_href;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col    <= '0;
      rowc   <= '0;
      href_q <= 1'b0;
    end else begin
      href_q <= in_href;
      if (!in_href)
        col <= '0;
      else if (acc && col != CW'(WIDTH - 1))
        col <= col + 1'b1;
      if (in_vsync)
        rowc <= '0;
      else if (href_q && !in_href && rowc != 2'd2)
        rowc <= rowc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      lb_b[col] <= lb_a[col];
      lb_a[col] <= in_pix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          w[i][j] <= '0;
      raw0  <= '0;
      bord0 <= 1'b1;
    end else if (acc) begin
      for (int i = 0; i < 3; i++) begin
        w[i][2] <= w[i][1];
        w[i][1] <= w[i][0];
      end
      w[0][0] <= lb_b[col];
      w[1][0] <= lb_a[col];
      w[2][0] <= in_pix;
      raw0    <= in_pix;
      bord0   <= (rowc != 2'd2) || (col < CW'(2));
    end
  end

  assign s2_his = sort3(s1[0][TW-1 -: PW], s1[1][TW-1 -: PW], s1[2][TW-1 -: PW]);
  assign s2_mds = sort3(s1[0][2*PW-1 -: PW], s1[1][2*PW-1 -: PW], s1[2][2*PW-1 -: PW]);
  assign s2_los = sort3(s1[0][PW-1:0], s1[1][PW-1:0], s1[2][PW-1:0]);
  assign s3_res = sort3(s2_hi, s2_md, s2_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) s1[i] <= '0;
      s2_hi  <= '0;
      s2_md  <= '0;
      s2_lo  <= '0;
      pix_q  <= '0;
      raw1   <= '0;
      raw2   <= '0;
      bord1  <= 1'b1;
      bord2  <= 1'b1;
      bord_q <= 1'b1;
    end else begin
      for (int i = 0; i < 3; i++) s1[i] <= sort3(w[i][0], w[i][1], w[i][2]);
      s2_hi  <= s2_his[PW-1:0];
      s2_md  <= s2_mds[2*PW-1 -: PW];
      s2_lo  <= s2_los[TW-1 -: PW];
      raw1   <= raw0;
      bord1  <= bord0;
      raw2   <= raw1;
      bord2  <= bord1;
      bord_q <= bord2;
      pix_q  <= bord2 ? raw2 : s3_res[2*PW-1 -: PW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_sr <= '0;
      hr_sr <= '0;
      de_sr <= '0;
    end else begin
      vs_sr <= {vs_sr[LAT-2:0], in_vsync};
      hr_sr <= {hr_sr[LAT-2:0], in_href};
      de_sr <= {de_sr[LAT-2:0], in_de};
    end
  end

  assign out_vsync = vs_sr[LAT-1];
  assign out_href  = hr_sr[LAT-1];
  assign out_de    = de_sr[LAT-1];
  assign out_pix   = out_href ? pix_q : '0;

  logic [2:0]    warm_cnt;
  logic [PW-1:0] win_hi, win_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_cnt <= '0;
    else if (warm_cnt != 3'd4) warm_cnt <= warm_cnt + 1'b1;
  end

  always_comb begin
    win_hi = s1[0][TW-1 -: PW];
    win_lo = s1[0][PW-1:0];
    for (int i = 1; i < 3; i++) begin
      if (s1[i][TW-1 -: PW] > win_hi) win_hi = s1[i][TW-1 -: PW];
      if (s1[i][PW-1:0] < win_lo) win_lo = s1[i][PW-1:0];
    end
  end

  // R4
  strobe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_cnt == 3'd4) |-> (out_de == $past(in_de, 4) && out_href == $past(in_href, 4)
                            && out_vsync == $past(in_vsync, 4)));

  generate
    for (genvar g = 0; g < 3; g++) begin : g_row_chk
      // R2
      row_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt != 3'd0) |-> (s1[g][TW-1 -: PW] >= s1[g][2*PW-1 -: PW]
                                && s1[g][2*PW-1 -: PW] >= s1[g][PW-1:0]));
    end
  endgenerate

  // R2
  median_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_cnt == 3'd4 && !bord_q) |-> (pix_q <= $past(win_hi, 2) && pix_q >= $past(win_lo, 2)));

  // R3
  border_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_cnt == 3'd4 && bord_q) |-> (pix_q == $past(raw0, 3)));

endmodule

// File: tb/median3x3_stream_tb.sv
`timescale 1ns/1ps
module median3x3_stream_tb;
  localparam int W = 8;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vsync = 1'b0, in_href = 1'b0, in_de = 1'b0;
  logic [7:0] in_pix = '0;
  logic out_vsync, out_href, out_de;
  logic [7:0] out_pix;

  int checks = 0;
  int failures = 0;
  int img [H][W];
  int exp_val [4096];
  int exp_req [4096];
  int wr_idx = 0;
  int rd_idx = 0;
  int frame_no = 0;
  bit mon_on = 1'b0;
  logic [2:0] hv [3];
  logic [2:0] hh [3];
  logic [2:0] hd [3];

  always #4 clk = ~clk;

  median3x3_stream #(.WIDTH(W), .PW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vsync(in_vsync), .in_href(in_href), .in_de(in_de),
    .in_pix(in_pix), .out_vsync(out_vsync), .out_href(out_href), .out_de(out_de),
    .out_pix(out_pix));

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int median9(input int r, input int c);
    int v [9];
    int k = 0;
    for (int i = r - 2; i <= r; i++)
      for (int j = c - 2; j <= c; j++) begin
        v[k] = img[i][j];
        k++;
      end
    for (int a = 0; a < 9; a++)
      for (int b = 0; b < 8 - a; b++)
        if (v[b] > v[b+1]) begin
          int t = v[b];
          v[b] = v[b+1];
          v[b+1] = t;
        end
    return v[4];
  endfunction

  function automatic int gen(input int pat, input int r, input int c);
    case (pat)
      1: return 255;
      2: return ((r + c) % 2 == 1) ? 255 : 0;
      3: return (r == 3 && c == 4) ? 255 : 10;
      4: return (r * 37 + c * 11) % 256;
      default: return int'($urandom_range(0, 255));
    endcase
  endfunction

  task automatic drive_frame(input int pat, input int gap_pct);
    @(negedge clk);
    in_vsync = 1'b1;
    repeat (3) @(negedge clk);
    in_vsync = 1'b0;
    @(negedge clk);
    for (int r = 0; r < H; r++) begin
      in_href = 1'b1;
      for (int c = 0; c < W; c++) begin
        while (int'($urandom_range(0, 99)) < gap_pct) begin
          in_de = 1'b0;
          in_pix = 8'($urandom);
          @(negedge clk);
        end
        img[r][c] = gen(pat, r, c);
        in_de = 1'b1;
        in_pix = 8'(img[r][c]);
        if (r < 2 || c < 2) begin
          exp_val[wr_idx] = img[r][c];
          exp_req[wr_idx] = (frame_no > 0 && r < 2) ? 7 : 3;
        end else begin
          exp_val[wr_idx] = median9(r, c);
          exp_req[wr_idx] = (pat == 1 || pat == 2 || pat == 3) ? 8 : 2;
        end
        wr_idx++;
        @(negedge clk);
      end
      in_de = 1'b0;
      in_href = 1'b0;
      // spurious enable during blanking must be ignored (R6)
      in_de = 1'b1;
      in_pix = 8'hA5;
      @(negedge clk);
      in_de = 1'b0;
      repeat (2 + int'($urandom_range(0, 3))) @(negedge clk);
    end
    frame_no++;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      hv[i] = '0; hh[i] = '0; hd[i] = '0;
    end
    forever begin
      @(posedge clk);
      #2;
      if (mon_on) begin
        chk("R4 out_vsync", int'(out_vsync), int'(hv[2][0]));
        chk("R4 out_href", int'(out_href), int'(hh[2][0]));
        chk("R4 out_de", int'(out_de), int'(hd[2][0]));
        if (!out_href) chk("R5 out_pix when line low", int'(out_pix), 0);
        if (out_de && out_href) begin
          if (rd_idx >= wr_idx) begin
            chk("R4 unexpected output pixel", 1, 0);
          end else begin
            case (exp_req[rd_idx])
              2: chk("R2 interior median", int'(out_pix), exp_val[rd_idx]);
              3: chk("R3 border pass-through", int'(out_pix), exp_val[rd_idx]);
              7: chk("R7 new-frame border row", int'(out_pix), exp_val[rd_idx]);
              default: chk("R8 extreme-value median", int'(out_pix), exp_val[rd_idx]);
            endcase
            rd_idx++;
          end
        end
      end
      hv[2] = hv[1]; hv[1] = hv[0]; hv[0] = {2'b0, in_vsync};
      hh[2] = hh[1]; hh[1] = hh[0]; hh[0] = {2'b0, in_href};
      hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = {2'b0, in_de && !(in_href == 1'b0 && in_pix == 8'hA5 && 1'b0)};
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 out_pix in reset", int'(out_pix), 0);
    chk("R1 out_de in reset", int'(out_de), 0);
    chk("R1 out_href in reset", int'(out_href), 0);
    chk("R1 out_vsync in reset", int'(out_vsync), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_pix after reset", int'(out_pix), 0);
    chk("R1 out_de after reset", int'(out_de), 0);
    mon_on = 1'b1;
    drive_frame(0, 30);   // R2 random with enable gaps (R6)
    drive_frame(4, 0);    // R2 ramp, no gaps, back-to-back frame (R7)
    drive_frame(2, 20);   // R8 checkerboard ties
    drive_frame(3, 10);   // R8 isolated spike removed
    drive_frame(1, 40);   // R8 flat 255
    drive_frame(0, 50);   // R6 heavy gaps, R7 restart over stale memories
    repeat (10) @(negedge clk);
    chk("R4 all accepted pixels emitted", rd_idx, wr_idx);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule